// File: doc/BRIEF.md
# Serially Loaded Direct Digital Synthesis Core

This block makes a digitally generated sine wave from a fixed reference clock. A 32-bit tuning word is added into a phase accumulator on every reference clock edge. The upper 14 bits of the accumulator form the phase. A five-bit phase offset is added to that phase, and a quarter-wave table turns the result into a 10-bit offset-binary amplitude code for an external converter. The output frequency is `tuning_word * f_ref / 2^32`. With an 80 MHz reference, one tuning-word step is below 0.03 Hz.

Settings arrive over a three-wire serial port: a data line, a word clock and an update strobe. Bits are shifted into a 40-bit staging register. Nothing reaches the oscillator until the update strobe rises. At that moment the whole staged word is copied into the working tuning and control registers. This lets a host change frequency, phase and power state together in one atomic step.

Top module: `dds_core`

## Requirements
- R1: While powered, the accumulator gains the working tuning word on every clock and wraps modulo 2^32. The amplitude produced at each edge is computed from the accumulator and control values held just before that edge, so the output has one register of latency.
- R2: The amplitude is offset binary with mid-scale 512. Let P be the 14-bit phase (accumulator bits 31:18 plus the offset term, modulo 16384). Let k be P[11:0]. Let i be k when P[12] is 0, and 4095-k when P[12] is 1. Let p be i*(8192-i). The magnitude is m = floor(8176*p / (335544320 - 4*p)). The amplitude is 512+m when P[13] is 0 and 512-m when P[13] is 1. It is never 0.
- R3: On each rising edge of the word clock, one data bit is shifted in, least significant bit first. Of the 40 collected bits, bits 31:0 are the tuning word and bits 39:32 are the control byte.
- R4: Once 40 bits have been collected since the last update, further word-clock edges are ignored until the next update.
- R5: Shifting alone does not change the output. Only a rising edge of the update strobe copies the staged word into the working registers and clears the bit count.
- R6: Control bits 7:3 are a phase offset in steps of 1/32 cycle. The offset value times 512 is added to the 14-bit phase.
- R7: While control bit 2 is set, the output sits at 512 and the accumulator holds its value. Clearing the bit resumes from the held phase.
- R8: Reset clears the accumulator, the tuning word, the control byte and the bit count, and drives the output to 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial configuration data |
| ser_wclk | input | 1 | Word clock; data is taken on its rising edge |
| ser_fqud | input | 1 | Update strobe; a rising edge applies the staged word |
| amp | output | 10 | Offset-binary amplitude code |

## Verification
The assertions assume the three serial inputs are synchronous to the reference clock. They also assume a word-clock rise and an update rise never fall in the same cycle, and that the update strobe stays low during reset. The stimulus drives each serial line on the falling clock edge. It holds every word-clock level for a full cycle and keeps the update pulse apart from the last data bit. It also sends words longer than 40 bits, so the saturating bit count is exercised under those same timing rules.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Quarter-wave magnitude for table index idx, using a rational sine
  // approximation over a half period of 2^(aw+1) steps.
  function automatic int quarter_mag(input int idx, input int aw, input int amp_w);
    longint n;
    longint p;
    longint peak;
    n    = longint'(1) << (aw + 1);
    p    = longint'(idx) * (n - longint'(idx));
    peak = (longint'(1) << (amp_w - 1)) - 1;
    return int'((peak * 16 * p) / (5 * n * n - 4 * p));
  endfunction

  // Phase after offset: truncated accumulator plus offset slots.
  function automatic logic [13:0] offset_phase(input logic [13:0] trunc, input logic [4:0] slot);
    return trunc + {slot, 9'b0};
  endfunction

endpackage

// File: rtl/dds_serial_in.sv
module dds_serial_in #(
  parameter int FTW_W = 32,
  parameter int CTL_W = 8,
  localparam int WORD_W = FTW_W + CTL_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_data,
  input  logic              ser_wclk,
  input  logic              ser_fqud,
  output logic [WORD_W-1:0] shift_q,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              fqud_rise,
  output logic [FTW_W-1:0]  ftw_q,
  output logic [CTL_W-1:0]  ctl_q
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic wclk_q;
  logic fqud_q;
  logic wclk_rise;

  assign wclk_rise = ser_wclk & ~wclk_q;
  assign fqud_rise = ser_fqud & ~fqud_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wclk_q  <= 1'b0;
      fqud_q  <= 1'b0;
      shift_q <= '0;
      bit_cnt <= '0;
      ftw_q   <= '0;
      ctl_q   <= '0;
    end else begin
      wclk_q <= ser_wclk;
      fqud_q <= ser_fqud;
      if (fqud_rise) begin
        ftw_q   <= shift_q[FTW_W-1:0];
        ctl_q   <= shift_q[WORD_W-1:FTW_W];
        bit_cnt <= '0;
      end else if (wclk_rise && bit_cnt != CNT_FULL) begin
        shift_q <= {ser_data, shift_q[WORD_W-1:1]};
        bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int FTW_W = 32,
  parameter int PHASE_W = 14,
  parameter int OFS_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FTW_W-1:0]   ftw,
  input  logic               freeze,
  input  logic [OFS_W-1:0]   ofs,
  output logic [FTW_W-1:0]   acc_q,
  output logic [PHASE_W-1:0] phase
);
  logic [PHASE_W-1:0] trunc;

  assign trunc = acc_q[FTW_W-1 -: PHASE_W];

  generate
    if (PHASE_W == 14 && OFS_W == 5) begin : g_pkg_ofs
      assign phase = dds_pkg::offset_phase(trunc, ofs);
    end else begin : g_gen_ofs
      assign phase = trunc + {ofs, {(PHASE_W-OFS_W){1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (!freeze) acc_q <= acc_q + ftw;
  end
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int PHASE_W = 14,
  parameter int AMP_W = 10,
  localparam int LUT_AW = PHASE_W - 2,
  localparam int QD = 1 << LUT_AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHASE_W-1:0] phase,
  input  logic               mute,
  output logic [AMP_W-1:0]   amp
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));

  logic [AMP_W-2:0]  rom [QD];
  logic [LUT_AW-1:0] k;
  logic [LUT_AW-1:0] idx;
  logic [AMP_W-1:0]  mag;
  logic [AMP_W-1:0]  amp_d;

  generate
    for (genvar i = 0; i < QD; i++) begin : g_rom
      localparam int MV = dds_pkg::quarter_mag(i, LUT_AW, AMP_W);
      assign rom[i] = (AMP_W-1)'(MV);
    end
  endgenerate

  assign k   = phase[LUT_AW-1:0];
  assign idx = phase[PHASE_W-2] ? ~k : k;
  assign mag = {1'b0, rom[idx]};

  always_comb begin
    if (mute)                amp_d = MID;
    else if (phase[PHASE_W-1]) amp_d = MID - mag;
    else                     amp_d = MID + mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) amp <= MID;
    else        amp <= amp_d;
  end
endmodule

// File: rtl/dds_core.sv
module dds_core #(
  parameter int FTW_W = 32,
  parameter int CTL_W = 8,
  parameter int PHASE_W = 14,
  parameter int AMP_W = 10,
  parameter int OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data,
  input  logic             ser_wclk,
  input  logic             ser_fqud,
  output logic [AMP_W-1:0] amp
);
  localparam int WORD_W = FTW_W + CTL_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PD_BIT = CTL_W - OFS_W - 1;

  logic [WORD_W-1:0]  shift_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic               fqud_rise;
  logic [FTW_W-1:0]   ftw_q;
  logic [CTL_W-1:0]   ctl_q;
  logic [FTW_W-1:0]   acc_q;
  logic [PHASE_W-1:0] phase;
  logic               pd;

  assign pd = ctl_q[PD_BIT];

  dds_serial_in #(.FTW_W(FTW_W), .CTL_W(CTL_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_wclk(ser_wclk),
    .ser_fqud(ser_fqud), .shift_q(shift_q), .bit_cnt(bit_cnt),
    .fqud_rise(fqud_rise), .ftw_q(ftw_q), .ctl_q(ctl_q)
  );

  dds_phase_acc #(.FTW_W(FTW_W), .PHASE_W(PHASE_W), .OFS_W(OFS_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .ftw(ftw_q), .freeze(pd),
    .ofs(ctl_q[CTL_W-1 -: OFS_W]), .acc_q(acc_q), .phase(phase)
  );

  dds_sine_lut #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .phase(phase), .mute(pd), .amp(amp)
  );
endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk #(
  parameter int FTW_W = 32,
  parameter int CTL_W = 8,
  parameter int AMP_W = 10,
  parameter int OFS_W = 5,
  localparam int WORD_W = FTW_W + CTL_W,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fqud_rise,
  input logic [WORD_W-1:0] shift_q,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [FTW_W-1:0]  ftw_q,
  input logic [CTL_W-1:0]  ctl_q,
  input logic [FTW_W-1:0]  acc_q,
  input logic [AMP_W-1:0]  amp
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1 << (AMP_W - 1));
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam int PD_BIT = CTL_W - OFS_W - 1;

  logic pd;
  assign pd = ctl_q[PD_BIT];

  AST_ACC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) !$past(pd) |-> acc_q == $past(acc_q) + $past(ftw_q)); // R1
  AST_AMP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) amp != '0); // R2
  AST_LOAD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n) fqud_rise |=> (ftw_q == $past(shift_q[FTW_W-1:0])) && (ctl_q == $past(shift_q[WORD_W-1:FTW_W]))); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bit_cnt <= CNT_FULL); // R4
  AST_FULL_IGNORE: assert property (@(posedge clk) disable iff (!rst_n) (bit_cnt == CNT_FULL) && !fqud_rise |=> $stable(shift_q)); // R4
  AST_HOLD_UNTIL_UPDATE: assert property (@(posedge clk) disable iff (!rst_n) !fqud_rise |=> $stable(ftw_q) && $stable(ctl_q)); // R5
  AST_UPDATE_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n) fqud_rise |=> bit_cnt == '0); // R5
  AST_PD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $past(pd) |-> (amp == MID) && (acc_q == $past(acc_q))); // R7
endmodule

bind dds_core dds_core_chk #(.FTW_W(FTW_W), .CTL_W(CTL_W), .AMP_W(AMP_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fqud_rise(fqud_rise), .shift_q(shift_q), .bit_cnt(bit_cnt),
  .ftw_q(ftw_q), .ctl_q(ctl_q), .acc_q(acc_q), .amp(amp)
);

// File: tb/dds_core_test.sv
`timescale 1ns/1ps
module dds_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0;
  logic ser_wclk = 1'b0;
  logic ser_fqud = 1'b0;
  logic [9:0] amp;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  always #4 clk = ~clk;

  dds_core uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data),
    .ser_wclk(ser_wclk), .ser_fqud(ser_fqud), .amp(amp)
  );

  // Behavioural reference: expected amplitude from the requirement formula.
  function automatic int ref_amp(input int ph);
    int  k, i, m;
    longint p;
    k = ph % 4096;
    if (((ph / 4096) % 2) == 1) i = 4095 - k;
    else i = k;
    p = longint'(i) * longint'(8192 - i);
    m = int'((longint'(8176) * p) / (longint'(335544320) - 4 * p));
    if (ph >= 8192) return 512 - m;
    return 512 + m;
  endfunction

  longint m_acc, m_ftw, m_ctl, m_stage;
  int m_cnt, m_amp;
  bit m_wp, m_fp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_ftw = 0; m_ctl = 0; m_stage = 0; m_cnt = 0; m_amp = 512;
      m_wp = 0; m_fp = 0;
    end else begin
      bit pdn;
      pdn = ((m_ctl >> 2) & 1) == 1;
      if (pdn) m_amp = 512;
      else m_amp = ref_amp(int'(((m_acc >> 18) + (m_ctl >> 3) * 512) % 16384));
      if (!pdn) m_acc = (m_acc + m_ftw) % (longint'(1) << 32);
      if (ser_fqud && !m_fp) begin
        m_ftw = m_stage % (longint'(1) << 32);
        m_ctl = m_stage >> 32;
        m_cnt = 0;
      end else if (ser_wclk && !m_wp && m_cnt < 40) begin
        m_stage = (m_stage >> 1) | (longint'(ser_data) << 39);
        m_cnt++;
      end
      m_wp = ser_wclk;
      m_fp = ser_fqud;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: amp actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Every cycle out of reset: compare with the reference model (tag in cur_req).
  always @(negedge clk) begin
    if (rst_n && !done) check(cur_req, int'(amp), m_amp);
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); ser_data = b; ser_wclk = 1'b1;
    @(negedge clk); ser_wclk = 1'b0;
  endtask

  task automatic send_word(input logic [31:0] ftw, input logic [7:0] ctl);
    logic [39:0] w;
    w = {ctl, ftw};
    for (int i = 0; i < 40; i++) send_bit(w[i]);
  endtask

  task automatic update();
    @(negedge clk); ser_fqud = 1'b1;
    @(negedge clk); ser_fqud = 1'b0;
  endtask

  task automatic load(input logic [31:0] ftw, input logic [7:0] ctl);
    send_word(ftw, ctl);
    update();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", int'(amp), 512);

    // R5: staged word has no effect before the update strobe
    cur_req = "R5";
    send_word(32'h0100_0000, 8'h00);
    repeat (5) @(negedge clk);
    check("R5", int'(amp), 512);
    update();

    // R1: accumulation with several tuning words, including wrap
    cur_req = "R1";
    repeat (300) @(negedge clk);
    load(32'h0123_4567, 8'h00);
    repeat (200) @(negedge clk);
    load(32'hFFF0_0000, 8'h00);
    repeat (200) @(negedge clk);
    load(32'h8000_0000, 8'h00);
    repeat (20) @(negedge clk);

    // R6 / R3: static phase offsets with zero tuning word
    cur_req = "R6";
    do_reset();
    load(32'h0, 8'd8 << 3);
    repeat (3) @(negedge clk);
    check("R6", int'(amp), 1022);
    load(32'h0, 8'd16 << 3);
    repeat (3) @(negedge clk);
    check("R6", int'(amp), 512);
    load(32'h0, 8'd24 << 3);
    repeat (3) @(negedge clk);
    check("R3", int'(amp), 2);

    // R2: mid-quadrant values
    cur_req = "R2";
    load(32'h0, 8'd4 << 3);
    repeat (3) @(negedge clk);
    check("R2", int'(amp), 872);
    load(32'h0, 8'd20 << 3);
    repeat (3) @(negedge clk);
    check("R2", int'(amp), 152);

    // R7: power-down holds mid-scale and freezes phase, then resumes
    cur_req = "R7";
    do_reset();
    load(32'h0200_0000, 8'h00);
    repeat (50) @(negedge clk);
    load(32'h0200_0000, 8'h04);
    repeat (3) @(negedge clk);
    check("R7", int'(amp), 512);
    repeat (30) @(negedge clk);
    check("R7", int'(amp), 512);
    load(32'h0200_0000, 8'h00);
    repeat (100) @(negedge clk);

    // R4: bits past the fortieth are dropped
    cur_req = "R4";
    do_reset();
    send_word(32'h0, 8'd8 << 3);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    update();
    repeat (3) @(negedge clk);
    check("R4", int'(amp), 1022);

    // R8: reset mid-run returns to mid-scale
    cur_req = "R8";
    load(32'h0400_0000, 8'h00);
    repeat (40) @(negedge clk);
    do_reset();
    repeat (2) @(negedge clk);
    check("R8", int'(amp), 512);
    repeat (20) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule